// File: doc/BRIEF.md
# Three-Bus Register-Add Datapath Controller

This block is a small processor datapath with three internal buses and the sequencer that steps it through one instruction: a three-operand register add. A register file with two combinational read ports drives buses A and B. The ALU result travels on bus C back to the register file, the memory address register and the instruction register. A dedicated incrementer advances the program counter while the ALU is busy copying that counter to the address register. A pass-through ALU mode (bus B copied to bus C) lets the address register and the instruction register be loaded across the same bus structure.

Each instruction takes four steps. Step 1 sends the counter to memory and requests a read. Step 2 waits for the memory completion strobe. Step 3 moves the fetched word into the instruction register. Step 4 adds two source registers, writes the destination and signals the end of the instruction. Memory latency is unbounded: the sequencer holds in step 2 until the strobe arrives. The write-back port is brought out so that the surrounding logic can observe each result.

Top module: `tb3_core`

## Requirements
- R1: After reset the program counter is 0, the step output is 0, the read request and end pulse are low, and register k of the eight-entry file holds the value k.
- R2: In step 1 (step_o=0) the block, on the next edge, drives mem_addr_o with the old counter value, raises mem_rd_o and advances pc_o by 4 (modulo 2^16), then enters step 2 (step_o=1).
- R3: While in step 2 with mem_done_i low, the block stays in step 2, keeps mem_rd_o high and holds pc_o.
- R4: When mem_done_i is high in step 2, mem_rdata_i is captured and mem_rd_o drops on the next edge (step_o=2); after step 3, ir_o shows the captured word. ir_o changes at no other time.
- R5: mem_done_i and mem_rdata_i have no effect outside step 2.
- R6: The instruction fields are destination [2:0], second source [5:3] and first source [8:6]; bits [15:9] are ignored. In step 4 (step_o=3) the destination register receives (first + second) modulo 2^16, and on the next edge wb_idx_o and wb_data_o show that write and end_o is high for exactly one cycle.
- R7: A register written in step 4 is read with its new value by the following instruction, including when the destination equals one or both sources.
- R8: After step 4 the block returns to step 1 (step_o=0); end_o is never high after any other step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr_o | output | 16 | Memory address register |
| mem_rd_o | output | 1 | Read request, held until completion |
| mem_rdata_i | input | 16 | Memory read data |
| mem_done_i | input | 1 | Memory completion strobe |
| ir_o | output | 16 | Instruction register |
| pc_o | output | 16 | Program counter |
| step_o | output | 2 | Current step, 0 to 3 for steps 1 to 4 |
| end_o | output | 1 | One-cycle end-of-instruction pulse |
| wb_idx_o | output | 3 | Register index written in the last step 4 |
| wb_data_o | output | 16 | Value written in the last step 4 |

## Verification
The hardest situation to reach is a register being read in the same instruction that overwrote it in the previous step 4, combined with memory strobes that arrive outside the wait step. Both appear only along particular instruction orders and timings. The bench sweeps every combination of the three register fields in order, so back-to-back dependencies and all cases where the destination aliases a source occur. Memory latency cycles through zero to three cycles, and stray strobes carrying wrong data are driven in steps 1, 3 and 4. The reset contents are first read out through add instructions of the form Rk = Rk + R0.

// File: rtl/tb3_pkg.sv
package tb3_pkg;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_WAIT   = 2'd1,
    ST_DECODE = 2'd2,
    ST_EXEC   = 2'd3
  } step_t;

  typedef enum logic [0:0] {
    ALU_PASS_B = 1'b0,
    ALU_ADD    = 1'b1
  } alu_op_t;

  typedef struct packed {
    logic    pc_to_b;   // counter drives bus B
    logic    mdr_to_b;  // data register drives bus B
    logic    ld_mar;    // address register takes bus C
    logic    ld_ir;     // instruction register takes bus C
    logic    rd_req;    // start a memory read
    logic    inc_pc;    // incrementer updates the counter
    logic    cap_mdr;   // memory data is latched
    logic    sel_k4;    // ALU A side takes the constant
    alu_op_t op;
    logic    wr_dst;    // register file write from bus C
    logic    fin;       // end of instruction
  } ctl_t;

endpackage

// File: rtl/tb3_regfile.sv
module tb3_regfile #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [AW-1:0] w_idx,
  input  logic [DW-1:0] w_data
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] regs [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[k] <= DW'(k);
      else if (we && (w_idx == AW'(k)))
        regs[k] <= w_data;
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];

endmodule

// File: rtl/tb3_alu.sv
module tb3_alu
  import tb3_pkg::*;
#(
  parameter int DW = 16,
  parameter int KVAL = 4
) (
  input  logic [DW-1:0] bus_a,
  input  logic [DW-1:0] bus_b,
  input  logic          sel_k4,
  input  alu_op_t       op,
  output logic [DW-1:0] bus_c
);
  logic [DW-1:0] a_side;

  assign a_side = sel_k4 ? DW'(KVAL) : bus_a;

  always_comb begin
    case (op)
      ALU_ADD:    bus_c = a_side + bus_b;
      default:    bus_c = bus_b;
    endcase
  end

endmodule

// File: rtl/tb3_seq.sv
module tb3_seq
  import tb3_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  mfc,
  output step_t step,
  output ctl_t  ctl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      step <= ST_FETCH;
    end else begin
      case (step)
        ST_FETCH:  step <= ST_WAIT;
        ST_WAIT:   if (mfc) step <= ST_DECODE;
        ST_DECODE: step <= ST_EXEC;
        default:   step <= ST_FETCH;
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    ctl.op = ALU_PASS_B;
    case (step)
      ST_FETCH: begin
        ctl.pc_to_b = 1'b1;
        ctl.ld_mar  = 1'b1;
        ctl.rd_req  = 1'b1;
        ctl.inc_pc  = 1'b1;
      end
      ST_WAIT: begin
        ctl.cap_mdr = mfc;
      end
      ST_DECODE: begin
        ctl.mdr_to_b = 1'b1;
        ctl.ld_ir    = 1'b1;
      end
      default: begin
        ctl.op     = ALU_ADD;
        ctl.wr_dst = 1'b1;
        ctl.fin    = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/tb3_core.sv
module tb3_core
  import tb3_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 3,
  parameter int PC_INC = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_done_i,
  output logic [DW-1:0] ir_o,
  output logic [DW-1:0] pc_o,
  output logic [1:0]    step_o,
  output logic          end_o,
  output logic [AW-1:0] wb_idx_o,
  output logic [DW-1:0] wb_data_o
);
  localparam int DST_LSB = 0;
  localparam int SB_LSB  = AW;
  localparam int SA_LSB  = 2 * AW;

  step_t         step;
  ctl_t          ctl;
  logic [DW-1:0] pc_q, mar_q, mdr_q, ir_q, wb_data_q;
  logic          rd_q, end_q;
  logic [AW-1:0] wb_idx_q;
  logic [DW-1:0] bus_a, bus_b, bus_c, rf_b;
  logic [AW-1:0] sa_idx, sb_idx, dst_idx;

  assign sa_idx  = ir_q[SA_LSB +: AW];
  assign sb_idx  = ir_q[SB_LSB +: AW];
  assign dst_idx = ir_q[DST_LSB +: AW];

  tb3_seq seq_i (
    .clk  (clk),
    .rst  (rst),
    .mfc  (mem_done_i),
    .step (step),
    .ctl  (ctl)
  );

  tb3_regfile #(.DW(DW), .AW(AW)) rf_i (
    .clk     (clk),
    .rst     (rst),
    .ra_idx  (sa_idx),
    .ra_data (bus_a),
    .rb_idx  (sb_idx),
    .rb_data (rf_b),
    .we      (ctl.wr_dst),
    .w_idx   (dst_idx),
    .w_data  (bus_c)
  );

  assign bus_b = ctl.pc_to_b  ? pc_q  :
                 ctl.mdr_to_b ? mdr_q : rf_b;

  tb3_alu #(.DW(DW), .KVAL(4)) alu_i (
    .bus_a  (bus_a),
    .bus_b  (bus_b),
    .sel_k4 (ctl.sel_k4),
    .op     (ctl.op),
    .bus_c  (bus_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      mar_q     <= '0;
      mdr_q     <= '0;
      ir_q      <= '0;
      rd_q      <= 1'b0;
      end_q     <= 1'b0;
      wb_idx_q  <= '0;
      wb_data_q <= '0;
    end else begin
      if (ctl.inc_pc)  pc_q  <= pc_q + DW'(PC_INC);
      if (ctl.ld_mar)  mar_q <= bus_c;
      if (ctl.cap_mdr) mdr_q <= mem_rdata_i;
      if (ctl.ld_ir)   ir_q  <= bus_c;
      if (ctl.rd_req)       rd_q <= 1'b1;
      else if (ctl.cap_mdr) rd_q <= 1'b0;
      end_q <= ctl.fin;
      if (ctl.wr_dst) begin
        wb_idx_q  <= dst_idx;
        wb_data_q <= bus_c;
      end
    end
  end

  assign mem_addr_o = mar_q;
  assign mem_rd_o   = rd_q;
  assign ir_o       = ir_q;
  assign pc_o       = pc_q;
  assign step_o     = step;
  assign end_o      = end_q;
  assign wb_idx_o   = wb_idx_q;
  assign wb_data_o  = wb_data_q;

endmodule

// File: rtl/tb3_core_chk.sv
module tb3_core_chk #(
  parameter int DW     = 16,
  parameter int PC_INC = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    step_o,
  input logic          mem_rd_o,
  input logic [DW-1:0] mem_addr_o,
  input logic [DW-1:0] pc_o,
  input logic          mem_done_i,
  input logic [DW-1:0] ir_o,
  input logic          end_o
);
  a_r2_read_issue: assert property (@(posedge clk) disable iff (rst)
    (step_o == 2'd0) |=> (mem_rd_o && step_o == 2'd1 &&
      mem_addr_o == $past(pc_o) &&
      pc_o == DW'($past(pc_o) + DW'(PC_INC))));

  a_r3_wait_hold: assert property (@(posedge clk) disable iff (rst)
    (step_o == 2'd1 && !mem_done_i) |=>
      (step_o == 2'd1 && mem_rd_o && $stable(pc_o)));

  a_r4_ir_only_step3: assert property (@(posedge clk) disable iff (rst)
    (step_o != 2'd2) |=> $stable(ir_o));

  a_r4_read_drops: assert property (@(posedge clk) disable iff (rst)
    (step_o == 2'd1 && mem_done_i) |=> (!mem_rd_o && step_o == 2'd2));

  a_r8_end_after_exec: assert property (@(posedge clk) disable iff (rst)
    (step_o == 2'd3) |=> (end_o && step_o == 2'd0));

  a_r8_no_stray_end: assert property (@(posedge clk) disable iff (rst)
    (step_o != 2'd3) |=> !end_o);

endmodule

bind tb3_core tb3_core_chk #(.DW(DW), .PC_INC(PC_INC)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .step_o     (step_o),
  .mem_rd_o   (mem_rd_o),
  .mem_addr_o (mem_addr_o),
  .pc_o       (pc_o),
  .mem_done_i (mem_done_i),
  .ir_o       (ir_o),
  .end_o      (end_o)
);

// File: tb/tb3_core_tb_top.sv
module tb3_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr_o;
  logic        mem_rd_o;
  logic [15:0] mem_rdata_i = '0;
  logic        mem_done_i = 1'b0;
  logic [15:0] ir_o;
  logic [15:0] pc_o;
  logic [1:0]  step_o;
  logic        end_o;
  logic [2:0]  wb_idx_o;
  logic [15:0] wb_data_o;

  int total = 0;
  int bad = 0;
  logic [15:0] model [8];
  logic [15:0] pc_exp = '0;

  always #2 clk = ~clk;

  tb3_core dut_i (
    .clk(clk), .rst(rst),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
    .mem_rdata_i(mem_rdata_i), .mem_done_i(mem_done_i),
    .ir_o(ir_o), .pc_o(pc_o), .step_o(step_o), .end_o(end_o),
    .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // one full instruction; entered at a negedge in step 1
  task automatic run_instr(input logic [15:0] instr, input int lat, input logic stray);
    logic [2:0]  a, b, d;
    logic [15:0] sum, pc_old;
    a = instr[8:6]; b = instr[5:3]; d = instr[2:0];
    pc_old = pc_exp;
    check(step_o == 2'd0, "R8 step1", step_o, 0);
    mem_done_i  = stray;          // R5: ignored in step 1
    mem_rdata_i = 16'hDEAD;
    tick();
    check(end_o == 1'b0, "R6 end one cycle", end_o, 0);
    check(mem_rd_o == 1'b1, "R2 read", mem_rd_o, 1);
    check(mem_addr_o == pc_old, "R2 addr", mem_addr_o, pc_old);
    pc_exp = pc_old + 16'd4;
    check(pc_o == pc_exp, "R2 pc", pc_o, pc_exp);
    check(step_o == 2'd1, "R5 stray done in step1", step_o, 1);
    mem_done_i = 1'b0;
    for (int w = 0; w < lat; w++) begin
      tick();
      check(step_o == 2'd1 && mem_rd_o && pc_o == pc_exp, "R3 wait hold",
            {step_o, mem_rd_o}, 3'b011);
    end
    mem_rdata_i = instr;
    mem_done_i  = 1'b1;
    tick();
    check(step_o == 2'd2 && !mem_rd_o, "R4 capture", {step_o, mem_rd_o}, 3'b100);
    mem_done_i  = stray;          // R5: ignored in step 3
    mem_rdata_i = ~instr;
    tick();
    check(ir_o == instr, "R4 ir", ir_o, instr);
    check(step_o == 2'd3, "R8 step4", step_o, 3);
    sum = model[a] + model[b];
    tick();
    mem_done_i = 1'b0;
    check(end_o == 1'b1, "R6 end", end_o, 1);
    check(wb_idx_o == d, "R6 wb idx", wb_idx_o, d);
    check(wb_data_o == sum, "R6 R7 wb data", wb_data_o, sum);
    check(step_o == 2'd0, "R8 return", step_o, 0);
    check(ir_o == instr, "R5 ir after stray", ir_o, instr);
    model[d] = sum;
  endtask

  initial begin
    for (int k = 0; k < 8; k++) model[k] = 16'(k);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(pc_o == 16'd0, "R1 pc", pc_o, 0);
    check(step_o == 2'd0, "R1 step", step_o, 0);
    check(!mem_rd_o && !end_o, "R1 rd/end", {mem_rd_o, end_o}, 0);
    // R1 register contents read back as Rk = Rk + R0
    for (int k = 0; k < 8; k++) begin
      run_instr({7'd0, 3'(k), 3'd0, 3'(k)}, k % 3, 1'b0);
      check(wb_data_o == 16'(k), "R1 reg reset value", wb_data_o, k);
    end
    // R6 R7: every field combination, R6 upper bits garbage
    for (int i = 0; i < 512; i++) begin
      logic [15:0] ins;
      ins = {7'(i * 37 + 5), 9'(i)};
      run_instr(ins, i % 4, 1'(i >> 2));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule